// File: doc/BRIEF.md
# SD Card SPI-Mode Command Issuer

This block turns a command index and a 32-bit argument into the framed command sequence that a memory card expects in SPI mode. It then reads the card's one-byte status reply. It does not shift bits itself. It hands one byte at a time to an external SPI byte shifter and waits for that shifter to report the byte it clocked in. Chip select stays low from the leading filler byte through one trailing byte after the reply. The block appends the 7-bit CRC to every frame, so a card that checks command CRCs accepts the frames.

The block can also run the power-up wake sequence. In that sequence it clocks out a fixed run of all-ones bytes while chip select stays high. The surrounding logic selects the slow shift rate for that phase. When either operation completes, the block pulses `done` once. The status byte that was kept is decoded into an idle flag, a CRC-error flag, a general fault flag and a no-card indication.

Top module: `sdspi_cmd_issuer`

## Requirements
- R1: A command begins when `start` is seen while idle. `cs_n` goes low in the same cycle that the first requested byte, 0xFF, is presented on `tx_byte`.
- R2: The second byte sent is 0x40 OR'd with `cmd_idx`. This places 0 in bit 7 and 1 in bit 6.
- R3: Bytes three to six carry `cmd_arg`, bits 31:24 first and bits 7:0 last.
- R4: The seventh byte is {crc, 1'b1}. The 7-bit crc uses polynomial x^7+x^3+1, starts from zero, and is taken MSB first over bytes two to six.
- R5: After the frame, the block requests 0xFF bytes to read the reply, at most 8 of them. The first received byte is always discarded. The first later byte with bit 7 = 0 ends the reply phase and is kept as `r1`. If no such byte arrives, `r1` holds the eighth received byte.
- R6: `no_resp` is 1 exactly when `r1` equals 0xFF.
- R7: `rsp_idle` reflects `r1` bit 0 and `rsp_crc_err` reflects `r1` bit 3. `rsp_fault` is 1 when any of `r1` bits 7:1 is set and `no_resp` is 0.
- R8: After the reply phase, one more 0xFF byte is sent with `cs_n` still low. Then `cs_n` returns high and `done` pulses for exactly one cycle.
- R9: `init_start` while idle sends 18 bytes of 0xFF with `cs_n` high throughout and then pulses `done` once.
- R10: If `init_start` and `start` arrive in the same idle cycle, the wake sequence runs and the command is dropped.
- R11: `start` and `init_start` are ignored while `busy` is 1. The ongoing transfer is unaffected, and nothing is sent after it finishes.
- R12: `xfer_req` stays high and `tx_byte` stays unchanged until `xfer_done` is returned for that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a command transaction |
| init_start | input | 1 | Request the wake sequence |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| xfer_req | output | 1 | Byte transfer requested from shifter |
| tx_byte | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Shifter finished the current byte |
| rx_byte | input | 8 | Byte the shifter clocked in, valid with `xfer_done` |
| cs_n | output | 1 | Card chip select, active low |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| r1 | output | 8 | Kept reply byte |
| no_resp | output | 1 | Reply byte was 0xFF |
| rsp_idle | output | 1 | Card reports idle state |
| rsp_crc_err | output | 1 | Card reports command CRC error |
| rsp_fault | output | 1 | Any error bit set in the reply |

## Verification
Two functions can be requested in the same cycle: the wake sequence and a command. The bench raises `init_start` and `start` together on one idle edge. It passes only if exactly 18 all-ones bytes leave with chip select high, `done` pulses once, and no command frame follows. A second test repeats both requests in the middle of a live command. It judges that the frame, the byte count and the reply are those of the first command alone.

// File: rtl/sdspi_cmd_pkg.sv
package sdspi_cmd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE,
        PH_FRAME,
        PH_POLL,
        PH_TAIL
    } phase_e;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;
    localparam int         FRAME_BYTES = 7;
    localparam int         CRC_BYTES   = 5;
    localparam logic [6:0] CRC7_POLY   = 7'h09;

endpackage

// File: rtl/sdspi_crc7.sv
module sdspi_crc7 #(
    parameter int MSG_BYTES = 5
) (
    input  logic [MSG_BYTES*8-1:0] msg,
    output logic [6:0]             crc
);
    import sdspi_cmd_pkg::*;

    localparam int MSG_BITS = MSG_BYTES * 8;

    logic [6:0] acc;
    logic       fb;

    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = MSG_BITS - 1; i >= 0; i--) begin
            fb  = msg[i] ^ acc[6];
            acc = {acc[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
        end
        crc = acc;
    end

endmodule

// File: rtl/sdspi_frame_mux.sv
module sdspi_frame_mux (
    input  logic [5:0]  idx,
    input  logic [31:0] arg,
    input  logic [6:0]  crc,
    input  logic [2:0]  sel,
    output logic [7:0]  frame_byte
);
    import sdspi_cmd_pkg::*;

    always_comb begin
        case (sel)
            3'd0:    frame_byte = FILL_BYTE;
            3'd1:    frame_byte = {2'b01, idx};
            3'd2:    frame_byte = arg[31:24];
            3'd3:    frame_byte = arg[23:16];
            3'd4:    frame_byte = arg[15:8];
            3'd5:    frame_byte = arg[7:0];
            3'd6:    frame_byte = {crc, 1'b1};
            default: frame_byte = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/sdspi_r1_judge.sv
module sdspi_r1_judge (
    input  logic [7:0] r1,
    output logic       no_resp,
    output logic       idle,
    output logic       crc_err,
    output logic       fault
);
    always_comb begin
        no_resp = (r1 == 8'hFF);
        idle    = r1[0];
        crc_err = r1[3];
        fault   = !no_resp && (|r1[7:1]);
    end

endmodule

// File: rtl/sdspi_cmd_issuer.sv
module sdspi_cmd_issuer #(
    parameter int POLL_LIMIT = 8,
    parameter int WAKE_BYTES = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        init_start,
    input  logic [5:0]  cmd_idx,
    input  logic [31:0] cmd_arg,
    output logic        xfer_req,
    output logic [7:0]  tx_byte,
    input  logic        xfer_done,
    input  logic [7:0]  rx_byte,
    output logic        cs_n,
    output logic        busy,
    output logic        done,
    output logic [7:0]  r1,
    output logic        no_resp,
    output logic        rsp_idle,
    output logic        rsp_crc_err,
    output logic        rsp_fault
);
    import sdspi_cmd_pkg::*;

    localparam int CNT_TOP0 = (WAKE_BYTES > POLL_LIMIT) ? WAKE_BYTES : POLL_LIMIT;
    localparam int CNT_TOP  = (CNT_TOP0 > FRAME_BYTES) ? CNT_TOP0 : FRAME_BYTES;
    localparam int CNT_W    = $clog2(CNT_TOP + 1);

    localparam logic [CNT_W-1:0] WAKE_LAST  = CNT_W'(WAKE_BYTES - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);
    localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_LIMIT - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [5:0]       idx;
        logic [31:0]      arg;
        logic [7:0]       r1;
        logic             cs_n;
        logic             done;
    } issuer_state_t;

    issuer_state_t st_q, st_d;

    logic [6:0] crc_w;
    logic [7:0] frame_byte_w;

    sdspi_crc7 #(
        .MSG_BYTES(CRC_BYTES)
    ) u_crc (
        .msg ({2'b01, st_q.idx, st_q.arg}),
        .crc (crc_w)
    );

    sdspi_frame_mux u_mux (
        .idx        (st_q.idx),
        .arg        (st_q.arg),
        .crc        (crc_w),
        .sel        (st_q.cnt[2:0]),
        .frame_byte (frame_byte_w)
    );

    sdspi_r1_judge u_judge (
        .r1      (st_q.r1),
        .no_resp (no_resp),
        .idle    (rsp_idle),
        .crc_err (rsp_crc_err),
        .fault   (rsp_fault)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (init_start) begin
                    st_d.phase = PH_WAKE;
                    st_d.cnt   = '0;
                end else if (start) begin
                    st_d.phase = PH_FRAME;
                    st_d.cnt   = '0;
                    st_d.idx   = cmd_idx;
                    st_d.arg   = cmd_arg;
                    st_d.cs_n  = 1'b0;
                end
            end
            PH_WAKE: begin
                if (xfer_done) begin
                    if (st_q.cnt == WAKE_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_FRAME: begin
                if (xfer_done) begin
                    if (st_q.cnt == FRAME_LAST) begin
                        st_d.phase = PH_POLL;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_POLL: begin
                if (xfer_done) begin
                    st_d.r1 = rx_byte;
                    if ((st_q.cnt != '0 && !rx_byte[7]) || st_q.cnt == POLL_LAST) begin
                        st_d.phase = PH_TAIL;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                if (xfer_done) begin
                    st_d.phase = PH_IDLE;
                    st_d.cs_n  = 1'b1;
                    st_d.done  = 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
                st_d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.cs_n  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy     = (st_q.phase != PH_IDLE);
        xfer_req = busy;
        tx_byte  = (st_q.phase == PH_FRAME) ? frame_byte_w : FILL_BYTE;
        cs_n     = st_q.cs_n;
        done     = st_q.done;
        r1       = st_q.r1;
    end

endmodule

// File: rtl/sdspi_cmd_issuer_chk.sv
module sdspi_cmd_issuer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_req,
    input logic [7:0] tx_byte,
    input logic       xfer_done,
    input logic       cs_n,
    input logic       done,
    input logic       no_resp,
    input logic       rsp_fault
);
    // R1: chip select falls together with the filler byte request
    assert_cs_fall_filler_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (xfer_req && tx_byte == 8'hFF));

    // R7: no-card and fault are exclusive
    assert_noresp_not_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        no_resp |-> !rsp_fault);

    // R8: completion pulse is one cycle wide
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: chip select is released when done pulses
    assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R12: request held until the shifter answers
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> xfer_req);

    // R12: outgoing byte stable while waiting
    assert_tx_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> $stable(tx_byte));

endmodule

bind sdspi_cmd_issuer sdspi_cmd_issuer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_req  (xfer_req),
    .tx_byte   (tx_byte),
    .xfer_done (xfer_done),
    .cs_n      (cs_n),
    .done      (done),
    .no_resp   (no_resp),
    .rsp_fault (rsp_fault)
);

// File: tb/sdspi_cmd_issuer_test.sv
module sdspi_cmd_issuer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        init_start = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        xfer_req;
    logic [7:0]  tx_byte;
    logic        xfer_done = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        cs_n, busy, done, no_resp, rsp_idle, rsp_crc_err, rsp_fault;
    logic [7:0]  r1;

    int vectors = 0;
    int errors = 0;
    int nbytes = 0;
    int done_cnt = 0;
    logic [7:0] tx_log [0:63];
    logic       cs_log [0:63];
    logic [7:0] resp [0:7];

    always #5 clk = ~clk;

    sdspi_cmd_issuer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .init_start(init_start),
        .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .xfer_req(xfer_req),
        .tx_byte(tx_byte), .xfer_done(xfer_done), .rx_byte(rx_byte),
        .cs_n(cs_n), .busy(busy), .done(done), .r1(r1), .no_resp(no_resp),
        .rsp_idle(rsp_idle), .rsp_crc_err(rsp_crc_err), .rsp_fault(rsp_fault)
    );

    // byte shifter model: logs each requested byte and replies after a delay
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_req) begin
                logic [7:0] rv;
                if (nbytes < 64) begin
                    tx_log[nbytes] = tx_byte;
                    cs_log[nbytes] = cs_n;
                end
                rv = 8'hFF;
                if (!cs_n && nbytes >= 7 && nbytes < 15) rv = resp[nbytes-7];
                nbytes = nbytes + 1;
                repeat (2) @(negedge clk);
                xfer_done = 1'b1;
                rx_byte   = rv;
                @(negedge clk);
                xfer_done = 1'b0;
                rx_byte   = 8'h00;
            end
        end
    end

    always @(negedge clk) if (done) done_cnt = done_cnt + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc7(input logic [39:0] m);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic b = m[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (b) c = c ^ 7'b0001001;
        end
        return c;
    endfunction

    task automatic set_resp(input logic [63:0] v);
        for (int i = 0; i < 8; i++) resp[i] = v[63-8*i -: 8];
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
        repeat (3) @(negedge clk);
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg);
        nbytes = 0; done_cnt = 0;
        @(negedge clk);
        cmd_idx = idx; cmd_arg = arg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    task automatic check_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [6:0] c = ref_crc7({2'b01, idx, arg});
        check("R1 filler", tx_log[0], 8'hFF);
        check("R2 cmd byte", tx_log[1], {2'b01, idx});
        check("R3 arg b31", tx_log[2], arg[31:24]);
        check("R3 arg b23", tx_log[3], arg[23:16]);
        check("R3 arg b15", tx_log[4], arg[15:8]);
        check("R3 arg b7", tx_log[5], arg[7:0]);
        check("R4 crc byte", tx_log[6], {c, 1'b1});
        for (int i = 0; i < 7; i++) check("R1 cs low in frame", cs_log[i], 1'b0);
    endtask

    task automatic check_tail(input int polls);
        check("R5 byte count", nbytes, 7 + polls + 1);
        for (int i = 7; i < 7 + polls; i++) check("R5 poll fill", tx_log[i], 8'hFF);
        check("R8 tail byte", tx_log[7+polls], 8'hFF);
        check("R8 tail cs low", cs_log[7+polls], 1'b0);
        check("R8 cs released", cs_n, 1'b1);
        check("R8 one done", done_cnt, 1);
    endtask

    task automatic t_reset();
        check("R8 reset cs_n", cs_n, 1'b1);
        check("R12 reset req", xfer_req, 1'b0);
        check("R11 reset busy", busy, 1'b0);
        check("R8 reset done", done, 1'b0);
    endtask

    task automatic t_go_idle();
        set_resp(64'hFF01_FFFF_FFFF_FFFF);
        issue(6'd0, 32'h0);
        check_frame(6'd0, 32'h0);
        check("R4 go-idle crc", tx_log[6], 8'h95);
        check_tail(2);
        check("R5 r1", r1, 8'h01);
        check("R7 idle", rsp_idle, 1'b1);
        check("R7 fault", rsp_fault, 1'b0);
        check("R6 no_resp", no_resp, 1'b0);
    endtask

    task automatic t_if_cond();
        set_resp(64'hFFFF_FF05_0000_0000);
        issue(6'd8, 32'h0000_01AA);
        check_frame(6'd8, 32'h0000_01AA);
        check("R4 if-cond crc", tx_log[6], 8'h87);
        check_tail(4);
        check("R5 r1", r1, 8'h05);
        check("R7 fault", rsp_fault, 1'b1);
        check("R7 crc_err", rsp_crc_err, 1'b0);
    endtask

    task automatic t_first_ignored();
        set_resp(64'h0009_0000_0000_0000);
        issue(6'd17, 32'h1234_5678);
        check_frame(6'd17, 32'h1234_5678);
        check_tail(2);
        check("R5 first discarded", r1, 8'h09);
        check("R7 crc_err", rsp_crc_err, 1'b1);
        check("R7 idle", rsp_idle, 1'b1);
    endtask

    task automatic t_no_card();
        set_resp(64'hFFFF_FFFF_FFFF_FFFF);
        issue(6'd55, 32'hA5C3_0F81);
        check_frame(6'd55, 32'hA5C3_0F81);
        check_tail(8);
        check("R6 r1", r1, 8'hFF);
        check("R6 no_resp", no_resp, 1'b1);
        check("R7 fault", rsp_fault, 1'b0);
    endtask

    task automatic t_budget_last();
        set_resp(64'hC1C1_C1C1_C1C1_C1C2);
        issue(6'd63, 32'hFFFF_FFFF);
        check_frame(6'd63, 32'hFFFF_FFFF);
        check_tail(8);
        check("R5 last byte kept", r1, 8'hC2);
        check("R6 no_resp", no_resp, 1'b0);
        check("R7 fault", rsp_fault, 1'b1);
    endtask

    task automatic t_crc_sweep();
        logic [5:0]  ids [0:3] = '{6'd1, 6'd9, 6'd41, 6'd58};
        logic [31:0] ags [0:3] = '{32'h4000_0000, 32'h0000_0001, 32'h8001_7FFE, 32'hDEAD_BEEF};
        for (int k = 0; k < 4; k++) begin
            set_resp(64'hFF00_FFFF_FFFF_FFFF);
            issue(ids[k], ags[k]);
            check_frame(ids[k], ags[k]);
            check("R5 ready reply", r1, 8'h00);
        end
    endtask

    task automatic t_wake();
        nbytes = 0; done_cnt = 0;
        @(negedge clk); init_start = 1'b1;
        @(negedge clk); init_start = 1'b0;
        wait_done();
        check("R9 wake count", nbytes, 18);
        for (int i = 0; i < 18; i++) begin
            check("R9 wake byte", tx_log[i], 8'hFF);
            check("R9 wake cs high", cs_log[i], 1'b1);
        end
        check("R9 one done", done_cnt, 1);
    endtask

    task automatic t_collide();
        nbytes = 0; done_cnt = 0;
        @(negedge clk);
        init_start = 1'b1; start = 1'b1; cmd_idx = 6'd5; cmd_arg = 32'h1;
        @(negedge clk);
        init_start = 1'b0; start = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        check("R10 only wake bytes", nbytes, 18);
        for (int i = 0; i < 18; i++) check("R10 cs high", cs_log[i], 1'b1);
        check("R10 one done", done_cnt, 1);
        check("R10 idle after", busy, 1'b0);
    endtask

    task automatic t_busy_ignore();
        set_resp(64'hFFFF_0100_0000_0000);
        nbytes = 0; done_cnt = 0;
        @(negedge clk);
        cmd_idx = 6'd2; cmd_arg = 32'h0102_0304; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (nbytes < 3) @(negedge clk);
        cmd_idx = 6'd40; cmd_arg = 32'hFFFF_0000; start = 1'b1; init_start = 1'b1;
        @(negedge clk);
        start = 1'b0; init_start = 1'b0;
        wait_done();
        repeat (30) @(negedge clk);
        check_frame(6'd2, 32'h0102_0304);
        check_tail(3);
        check("R11 reply kept", r1, 8'h01);
        check("R11 nothing after", nbytes, 11);
        check("R11 not busy", busy, 1'b0);
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_go_idle();
        t_if_cond();
        t_first_ignored();
        t_no_card();
        t_budget_last();
        t_crc_sweep();
        t_wake();
        t_collide();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++; errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule